// File: doc/BRIEF.md
# Abstract Qubit Line Tracker

This block follows one abstracted qubit line through a stream of gate operations. The line state has two parts. A 2-bit status code records whether the line is in superposition and how many Hadamard-type operations have reached it. A 1-bit basis value holds the computational basis state, where 0 is basis zero and 1 is basis one. The block can take one operation per clock. A Hadamard-type operation steps the status code through a small saturating sequence and does not touch the basis bit. A controlled-swap operation either loads the whole (status, basis) pair of the partner line or keeps the line as it is. The choice depends on the basis bit of the control line.

A gate-level checker places one tracker on each data and control line of an abstracted circuit. For each swap gate, it connects the partner line's outputs to the swap-partner inputs. The status codes and basis values read at the end of the stream can then be compared with the expected multiplexer behaviour of the circuit.

Top module: `superpos_line_tracker`

## Requirements
- R1: While rst_ni is low, status_o is 00 and basis_o equals init_q_i. After release, illegal_o is 0.
- R2: A valid operation with op code 01 (Hadamard-type) moves status_o from 00 to 01, from 01 to 10, from 10 to 11, and from 11 to 10. The new value appears at the next clock edge.
- R3: A Hadamard-type operation leaves basis_o unchanged.
- R4: A valid operation with op code 10 (controlled swap) while ctrl_q_i is 1 loads partner_s_i into status_o and partner_q_i into basis_o at the next edge.
- R5: A controlled swap while ctrl_q_i is 0 leaves status_o and basis_o unchanged.
- R6: While op_valid_i is 0, status_o and basis_o hold, whatever the op, control and partner inputs are.
- R7: A valid operation with op code 00 or 11 leaves status_o and basis_o unchanged. It drives illegal_o high for the single following cycle.
- R8: illegal_o is 0 in any cycle that follows a cycle without a valid illegal op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_q_i | input | 1 | Basis value loaded while reset is held |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Op code: 01 Hadamard-type, 10 controlled swap, other codes illegal |
| partner_s_i | input | 2 | Status code of the swap partner line |
| partner_q_i | input | 1 | Basis value of the swap partner line |
| ctrl_q_i | input | 1 | Basis value of the swap control line |
| status_o | output | 2 | Current status code |
| basis_o | output | 1 | Current basis value |
| illegal_o | output | 1 | One-cycle flag after an illegal op code |

## Verification
The bench sweeps every starting pair of status and basis value. Against each one it applies every op code, both strobe levels, both control values and every partner pair. Repeated Hadamard-type operations from 00 check that 11 falls back to 10 rather than wrapping to 00. Partner pairs that differ from the current state separate a taken swap from a passed-through one. Pairs that equal the current state are included as well, and they show that a swap neither corrupts nor flips the line. Both illegal codes are given non-trivial partner and control inputs, so that an illegal code wrongly decoded as a swap or a Hadamard changes the state and is seen.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned STATUS_W = 2;
  localparam int unsigned OP_W     = 2;

  typedef logic [STATUS_W-1:0] status_t;

  typedef enum logic [OP_W-1:0] {
    OP_RSV0 = 2'b00,
    OP_HAD  = 2'b01,
    OP_SWAP = 2'b10,
    OP_RSV3 = 2'b11
  } op_e;

  localparam status_t ST_FRESH   = 2'b00;
  localparam status_t ST_SUP_ONE = 2'b01;
  localparam status_t ST_DEF_MNY = 2'b10;
  localparam status_t ST_SUP_MNY = 2'b11;
endpackage

// File: rtl/slt_op_decode.sv
module slt_op_decode
  import slt_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output logic            do_had_o,
  output logic            do_swap_o,
  output logic            bad_o
);
  always_comb begin
    do_had_o  = 1'b0;
    do_swap_o = 1'b0;
    bad_o     = 1'b0;
    if (valid_i) begin
      unique case (op_e'(op_i))
        OP_HAD:  do_had_o  = 1'b1;
        OP_SWAP: do_swap_o = 1'b1;
        default: bad_o     = 1'b1;
      endcase
    end
  end

  // decoded strobes are mutually exclusive
  always_comb begin
    onehot_dec_chk: assert ($onehot0({do_had_o, do_swap_o, bad_o}));
  end
endmodule

// File: rtl/slt_had_step.sv
module slt_had_step
  import slt_pkg::*;
(
  input  status_t cur_i,
  output status_t nxt_o
);
  // saturating step: definite-many and super-many alternate
  always_comb begin
    unique case (cur_i)
      ST_FRESH:   nxt_o = ST_SUP_ONE;
      ST_SUP_ONE: nxt_o = ST_DEF_MNY;
      ST_DEF_MNY: nxt_o = ST_SUP_MNY;
      default:    nxt_o = ST_DEF_MNY;
    endcase
  end

  // R2
  always_comb begin
    had_flip_chk: assert (nxt_o[0] != cur_i[0]);
  end
endmodule

// File: rtl/slt_swap_sel.sv
module slt_swap_sel
  import slt_pkg::*;
(
  input  logic    ctrl_q_i,
  input  status_t own_s_i,
  input  logic    own_q_i,
  input  status_t prt_s_i,
  input  logic    prt_q_i,
  output status_t sel_s_o,
  output logic    sel_q_o
);
  always_comb begin
    sel_s_o = ctrl_q_i ? prt_s_i : own_s_i;
    sel_q_o = ctrl_q_i ? prt_q_i : own_q_i;
  end
endmodule

// File: rtl/superpos_line_tracker.sv
module superpos_line_tracker
  import slt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_q_i,
  input  logic                op_valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [STATUS_W-1:0] partner_s_i,
  input  logic                partner_q_i,
  input  logic                ctrl_q_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                basis_o,
  output logic                illegal_o
);
  status_t s_q, s_d, had_s, swp_s;
  logic    q_q, q_d, swp_q;
  logic    ill_q;
  logic    do_had, do_swap, bad;

  slt_op_decode u_dec (
    .valid_i   (op_valid_i),
    .op_i      (op_i),
    .do_had_o  (do_had),
    .do_swap_o (do_swap),
    .bad_o     (bad)
  );

  slt_had_step u_had (
    .cur_i (s_q),
    .nxt_o (had_s)
  );

  slt_swap_sel u_swp (
    .ctrl_q_i (ctrl_q_i),
    .own_s_i  (s_q),
    .own_q_i  (q_q),
    .prt_s_i  (partner_s_i),
    .prt_q_i  (partner_q_i),
    .sel_s_o  (swp_s),
    .sel_q_o  (swp_q)
  );

  always_comb begin
    s_d = s_q;
    q_d = q_q;
    if (do_had) begin
      s_d = had_s;
    end else if (do_swap) begin
      s_d = swp_s;
      q_d = swp_q;
    end
  end

  // reset value of q follows the init input while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= ST_FRESH;
      q_q   <= init_q_i;
      ill_q <= 1'b0;
    end else begin
      s_q   <= s_d;
      q_q   <= q_d;
      ill_q <= bad;
    end
  end

  assign status_o  = s_q;
  assign basis_o   = q_q;
  assign illegal_o = ill_q;

  // R2
  had_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b01 && status_o == 2'b00) |=> status_o == 2'b01);
  // R2
  had_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b01 && status_o == 2'b11) |=> status_o == 2'b10);
  // R3
  had_keep_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b01) |=> $stable(basis_o));
  // R4
  swap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b10 && ctrl_q_i)
      |=> (status_o == $past(partner_s_i) && basis_o == $past(partner_q_i)));
  // R5
  swap_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b10 && !ctrl_q_i)
      |=> ($stable(status_o) && $stable(basis_o)));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ($stable(status_o) && $stable(basis_o)));
  // R7
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i[1] == op_i[0])
      |=> (illegal_o && $stable(status_o) && $stable(basis_o)));
  // R8
  flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && op_i[1] == op_i[0]) |=> !illegal_o);
endmodule

// File: tb/superpos_line_tracker_tb_top.sv
module superpos_line_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_q = 1'b0;
  logic       vld = 1'b0;
  logic [1:0] op = 2'b00;
  logic [1:0] ps = 2'b00;
  logic       pq = 1'b0;
  logic       cq = 1'b0;
  logic [1:0] st;
  logic       bq;
  logic       ill;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  superpos_line_tracker dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .init_q_i    (init_q),
    .op_valid_i  (vld),
    .op_i        (op),
    .partner_s_i (ps),
    .partner_q_i (pq),
    .ctrl_q_i    (cq),
    .status_o    (st),
    .basis_o     (bq),
    .illegal_o   (ill)
  );

  function automatic logic [1:0] had_next(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s + 2'd1;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive at negedge, sample at following negedge (one register stage)
  task automatic step(input logic v, input logic [1:0] o, input logic [1:0] s,
                      input logic q, input logic c);
    @(negedge clk);
    vld = v; op = o; ps = s; pq = q; cq = c;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    // R1: reset state with both init values
    for (int iv = 0; iv < 2; iv++) begin
      rst_n = 1'b0;
      init_q = iv[0];
      #5;
      check("R1", {1'b0, st, bq}, {1'b0, 2'b00, iv[0]});
      @(negedge clk);
      check("R1", {1'b0, st, bq}, {1'b0, 2'b00, iv[0]});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {3'b0, ill}, 4'b0);
    end

    // R2 R3: Hadamard chain from 00, saturating at 10/11
    begin
      logic [1:0] es = 2'b00;
      for (int k = 0; k < 6; k++) begin
        step(1'b1, 2'b01, 2'b11, 1'b0, 1'b1);
        es = had_next(es);
        check("R2", {2'b0, st}, {2'b0, es});
        check("R3", {3'b0, bq}, {3'b0, 1'b1});
      end
    end

    // exhaustive sweep
    for (int s0 = 0; s0 < 4; s0++)
      for (int q0 = 0; q0 < 2; q0++)
        for (int v = 0; v < 2; v++)
          for (int o = 0; o < 4; o++)
            for (int c = 0; c < 2; c++)
              for (int p = 0; p < 8; p++) begin
                logic [1:0] es;
                logic       eq;
                logic       ei;
                string      rq;
                // load start state through a taken swap (R4 path)
                step(1'b1, 2'b10, s0[1:0], q0[0], 1'b1);
                check("R4", {1'b0, st, bq}, {1'b0, s0[1:0], q0[0]});
                step(v[0], o[1:0], p[2:1], p[0], c[0]);
                es = s0[1:0]; eq = q0[0]; ei = 1'b0;
                if (v == 0) rq = "R6";
                else if (o == 1) begin es = had_next(es); rq = "R2"; end
                else if (o == 2) begin
                  if (c == 1) begin es = p[2:1]; eq = p[0]; rq = "R4"; end
                  else rq = "R5";
                end else begin ei = 1'b1; rq = "R7"; end
                check(rq, {st, bq, ill}, {es, eq, ei});
                // flag lasts exactly one cycle
                @(negedge clk);
                check("R8", {3'b0, ill}, 4'b0);
              end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule